// File: doc/BRIEF.md
# Bunch-Crossing Tick and Turn Tracker

This block keeps track of where the machine is inside its revolution. A tick number counts bunch crossings within one turn, and a turn number counts completed revolutions. The tick number advances on every crossing clock. After the last crossing of a turn it starts again at one, and the turn number steps up on that same edge. Both values are driven out in parallel, as an 8-bit tick field and a 16-bit turn field, so that a link transmitter can send them on.

The block also keeps a record of crossings for a two-level trigger. Whenever a first-level accept arrives, the tick and turn value of that cycle is written into a small first-in, first-out store. Each advertised second-level decision removes the oldest entry and presents it at the output, together with a one-cycle valid strobe. A synchronous initialize input clears the counts, the store and the error flags. A build parameter produces a free-running variant that never responds to initialize and can only be cleared by the power-on reset.

Top module: `bx_tick_turn_tracker`

## Requirements
- R1: While `rst` is high and after it is released, before any other input acts, the outputs are: tick 1, turn 0, store empty, not full, both flags clear, valid low and popped value 0.
- R2: With no initialize, the tick output rises by one at each clock edge and stays inside 1..159.
- R3: On the edge after the tick reads 159, the tick becomes 1 and the turn rises by one on that same edge. The turn is a 16-bit value.
- R4: An initialize sets the tick to 1 and the turn to 0 on the next edge. On the same edge it empties the store, clears both flags and drops any accept given in that cycle.
- R5: When `IGNORE_INIT` is 1, initialize has no effect: the counts keep advancing and the store is not cleared.
- R6: An accept stores the tick and turn shown on the outputs in that cycle. A decision on a non-empty store presents the oldest entry on the popped outputs on the next edge, with `l1_valid_o` high for exactly that cycle. The popped value holds between pops.
- R7: Entries leave the store in the order in which they were captured.
- R8: An accept while the store holds 16 entries and no decision is given drops the entry and sets `overflow_o`. The flag stays set until initialize or reset.
- R9: A decision while the store is empty is ignored: valid stays low and the popped value holds. It sets `underflow_o`, which stays set until initialize or reset.
- R10: An accept and a decision in the same cycle on a non-empty store are both carried out, even when the store is full; no overflow results. On an empty store the accept is kept and the decision counts as an underflow.
- R11: `fifo_empty_o` is high exactly when no entries are held, and `fifo_full_o` is high exactly when 16 are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous active-high reset |
| init_i | input | 1 | Synchronous initialize of counts and store |
| l1_accept_i | input | 1 | First-level accept; captures the current crossing |
| l2_decision_i | input | 1 | Second-level decision advertised; releases one entry |
| tick_o | output | 8 | Current tick within the turn, 1..159 |
| turn_o | output | 16 | Current turn count |
| l1_tick_o | output | 8 | Tick field of the last released entry |
| l1_turn_o | output | 16 | Turn field of the last released entry |
| l1_valid_o | output | 1 | High for one cycle when a released entry is presented |
| fifo_empty_o | output | 1 | Store holds no entries |
| fifo_full_o | output | 1 | Store holds the maximum number of entries |
| overflow_o | output | 1 | Sticky: an accept was dropped |
| underflow_o | output | 1 | Sticky: a decision arrived with nothing stored |

## Verification
The assertions assume that inputs change only between clock edges and that `rst` is high at the first edge. The step and wrap properties also assume that initialize is the only thing that interrupts counting. The stimulus therefore drives every input on the falling clock edge and holds reset for several edges. It uses initialize only through the same per-cycle task, so the checks always see a fully defined state. The vector table fills the store beyond its depth, drains it beyond empty, and issues combined accept and decision cycles on full, partly full and empty stores. These cover the overflow, underflow and simultaneous cases without relying on timing assumptions.

// File: rtl/bx_tt_pkg.sv
package bx_tt_pkg;
  localparam int TICK_W = 8;
  localparam int TURN_W = 16;

  typedef struct packed {
    logic [TURN_W-1:0] turn;
    logic [TICK_W-1:0] tick;
  } bx_stamp_t;

  localparam int STAMP_W = $bits(bx_stamp_t);
endpackage

// File: rtl/bx_tt_counter.sv
module bx_tt_counter
  import bx_tt_pkg::*;
#(
  parameter int TICKS_PER_TURN = 159
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      clr_i,
  output bx_stamp_t stamp_o
);
  localparam logic [TICK_W-1:0] FIRST_TICK = TICK_W'(1);
  localparam logic [TICK_W-1:0] LAST_TICK  = TICK_W'(TICKS_PER_TURN);

  logic [TICK_W-1:0] tick_q;
  logic [TURN_W-1:0] turn_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      tick_q <= FIRST_TICK;
      turn_q <= '0;
    end else if (tick_q == LAST_TICK) begin
      tick_q <= FIRST_TICK;
      turn_q <= turn_q + 1'b1;
    end else begin
      tick_q <= tick_q + 1'b1;
    end
  end

  assign stamp_o.tick = tick_q;
  assign stamp_o.turn = turn_q;

  // R2: tick stays within the turn
  p_tick_range_r2: assert property (@(posedge clk) disable iff (rst)
    (tick_q >= FIRST_TICK) && (tick_q <= LAST_TICK));

  // R2: plain step between wraps
  p_tick_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && tick_q != LAST_TICK) |=>
      (tick_q == $past(tick_q) + 1'b1) && $stable(turn_q));

  // R3: wrap and turn advance on one edge
  p_turn_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && tick_q == LAST_TICK) |=>
      (tick_q == FIRST_TICK) && (turn_q == $past(turn_q) + 1'b1));

  // R4: initialize restarts both counts
  p_init_counts_r4: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (tick_q == FIRST_TICK) && (turn_q == '0));
endmodule

// File: rtl/bx_tt_fifo.sv
module bx_tt_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] dout_o,
  output logic             valid_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             overflow_o,
  output logic             underflow_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    count_q;
  logic [WIDTH-1:0] dout_q;
  logic             valid_q, ovf_q, unf_q;
  logic             do_pop, do_push;

  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == FULL_CNT);
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full_o || do_pop);

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (do_push && !clr_i) mem[wr_ptr_q] <= din_i;
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst)         dout_q <= '0;
    else if (do_pop && !clr_i) dout_q <= mem[rd_ptr_q];
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      valid_q  <= 1'b0;
      ovf_q    <= 1'b0;
      unf_q    <= 1'b0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
      unique case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
      valid_q <= do_pop;
      ovf_q   <= ovf_q | (push_i && !do_push);
      unf_q   <= unf_q | (pop_i && !do_pop);
    end
  end

  assign dout_o      = dout_q;
  assign valid_o     = valid_q;
  assign overflow_o  = ovf_q;
  assign underflow_o = unf_q;

  // R11: flags exclusive and count bounded
  p_empty_full_r11: assert property (@(posedge clk) disable iff (rst)
    !(empty_o && full_o) && (count_q <= FULL_CNT));

  // R6: a real pop presents data on the next edge
  p_pop_valid_r6: assert property (@(posedge clk) disable iff (rst || clr_i)
    (pop_i && !empty_o) |=> valid_o);

  // R8: dropped push leaves the store full and flags it
  p_drop_full_r8: assert property (@(posedge clk) disable iff (rst || clr_i)
    (push_i && !pop_i && full_o) |=> full_o && overflow_o);

  // R8: overflow is sticky
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst || clr_i)
    overflow_o |=> overflow_o);

  // R9: empty pop gives no data and flags it
  p_empty_pop_r9: assert property (@(posedge clk) disable iff (rst || clr_i)
    (pop_i && empty_o) |=> underflow_o && !valid_o && $stable(dout_o));

  // R9: underflow is sticky
  p_unf_sticky_r9: assert property (@(posedge clk) disable iff (rst || clr_i)
    underflow_o |=> underflow_o);

  // R10: simultaneous push and pop keep the fill level
  p_push_pop_r10: assert property (@(posedge clk) disable iff (rst || clr_i)
    (push_i && pop_i && !empty_o) |=> $stable(count_q) && !$rose(overflow_o));
endmodule

// File: rtl/bx_tick_turn_tracker.sv
module bx_tick_turn_tracker
  import bx_tt_pkg::*;
#(
  parameter int TICKS_PER_TURN = 159,
  parameter int FIFO_DEPTH     = 16,
  parameter bit IGNORE_INIT    = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_i,
  input  logic              l1_accept_i,
  input  logic              l2_decision_i,
  output logic [TICK_W-1:0] tick_o,
  output logic [TURN_W-1:0] turn_o,
  output logic [TICK_W-1:0] l1_tick_o,
  output logic [TURN_W-1:0] l1_turn_o,
  output logic              l1_valid_o,
  output logic              fifo_empty_o,
  output logic              fifo_full_o,
  output logic              overflow_o,
  output logic              underflow_o
);
  logic      init_eff;
  bx_stamp_t now_stamp, popped;

  generate
    if (IGNORE_INIT) begin : g_free_running
      assign init_eff = 1'b0;
      // R5: initialize must not disturb counting
      p_ignore_init_r5: assert property (@(posedge clk) disable iff (rst)
        (init_i && tick_o != TICK_W'(TICKS_PER_TURN)) |=>
          (tick_o == $past(tick_o) + 1'b1));
    end else begin : g_init_driven
      assign init_eff = init_i;
    end
  endgenerate

  bx_tt_counter #(
    .TICKS_PER_TURN(TICKS_PER_TURN)
  ) i_counter (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (init_eff),
    .stamp_o(now_stamp)
  );

  bx_tt_fifo #(
    .DEPTH(FIFO_DEPTH),
    .WIDTH(STAMP_W)
  ) i_fifo (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (init_eff),
    .push_i     (l1_accept_i),
    .din_i      (now_stamp),
    .pop_i      (l2_decision_i),
    .dout_o     (popped),
    .valid_o    (l1_valid_o),
    .empty_o    (fifo_empty_o),
    .full_o     (fifo_full_o),
    .overflow_o (overflow_o),
    .underflow_o(underflow_o)
  );

  assign tick_o    = now_stamp.tick;
  assign turn_o    = now_stamp.turn;
  assign l1_tick_o = popped.tick;
  assign l1_turn_o = popped.turn;
endmodule

// File: tb/test_bx_tick_turn_tracker.sv
module test_bx_tick_turn_tracker;
  localparam int LAST  = 159;
  localparam int DEPTH = 16;
  localparam int NV    = 12;
  // {repeat[7:0], gap[7:0], accept, decision, init}
  localparam logic [18:0] VECS [NV] = '{
    {8'd3,  8'd5,   3'b100},  // R6 three captures
    {8'd3,  8'd1,   3'b010},  // R7 drain in order
    {8'd2,  8'd0,   3'b010},  // R9 pops on empty
    {8'd20, 8'd2,   3'b100},  // R8 overfill
    {8'd4,  8'd0,   3'b110},  // R10 both while full
    {8'd1,  8'd0,   3'b001},  // R4 initialize
    {8'd1,  8'd0,   3'b110},  // R10 both on empty
    {8'd5,  8'd7,   3'b100},
    {8'd3,  8'd0,   3'b110},
    {8'd7,  8'd11,  3'b010},
    {8'd2,  8'd200, 3'b000},  // R3 wraps
    {8'd1,  8'd0,   3'b101}   // R4 accept dropped by init
  };

  logic clk = 1'b0, rst = 1'b1, init = 1'b0, acc = 1'b0, dec = 1'b0;
  logic [7:0]  tick, l1_tick, f_tick, f_l1_tick;
  logic [15:0] turn, l1_turn, f_turn, f_l1_turn;
  logic valid, empty, full, ovf, unf;
  logic f_valid, f_empty, f_full, f_ovf, f_unf;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // bench model
  int          m_tick = 1, f_mtick = 1;
  logic [15:0] m_turn = '0, f_mturn = '0;
  logic [23:0] q [DEPTH];
  int          q_head = 0, q_cnt = 0;
  logic [23:0] m_out = '0;
  bit          m_valid = 0, m_ovf = 0, m_unf = 0;
  logic [23:0] cap [3];

  always #5 clk = ~clk;

  bx_tick_turn_tracker i_bx_tick_turn_tracker (
    .clk(clk), .rst(rst), .init_i(init), .l1_accept_i(acc), .l2_decision_i(dec),
    .tick_o(tick), .turn_o(turn), .l1_tick_o(l1_tick), .l1_turn_o(l1_turn),
    .l1_valid_o(valid), .fifo_empty_o(empty), .fifo_full_o(full),
    .overflow_o(ovf), .underflow_o(unf));

  bx_tick_turn_tracker #(.IGNORE_INIT(1'b1)) i_bx_tick_turn_tracker_free (
    .clk(clk), .rst(rst), .init_i(init), .l1_accept_i(1'b0), .l2_decision_i(1'b0),
    .tick_o(f_tick), .turn_o(f_turn), .l1_tick_o(f_l1_tick), .l1_turn_o(f_l1_turn),
    .l1_valid_o(f_valid), .fifo_empty_o(f_empty), .fifo_full_o(f_full),
    .overflow_o(f_ovf), .underflow_o(f_unf));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R2 tick", 32'(tick), 32'(m_tick));
    chk("R3 turn", 32'(turn), 32'(m_turn));
    chk("R6 popped value", 32'({l1_turn, l1_tick}), 32'(m_out));
    chk("R6 valid", 32'(valid), 32'(m_valid));
    chk("R11 empty", 32'(empty), 32'(q_cnt == 0));
    chk("R11 full", 32'(full), 32'(q_cnt == DEPTH));
    chk("R8 overflow", 32'(ovf), 32'(m_ovf));
    chk("R9 underflow", 32'(unf), 32'(m_unf));
    chk("R5 free tick", 32'(f_tick), 32'(f_mtick));
    chk("R5 free turn", 32'(f_turn), 32'(f_mturn));
    chk("R5 free store", 32'({f_empty, f_valid}), 32'(2'b10));
  endtask

  // one clock: drive at the falling edge, update model at the rising edge
  task automatic cycle(input bit a, input bit d, input bit in);
    logic [23:0] stamp;
    acc = a; dec = d; init = in;
    stamp = {m_turn, 8'(m_tick)};
    @(posedge clk);
    if (in) begin
      m_tick = 1; m_turn = '0; q_head = 0; q_cnt = 0;
      m_valid = 0; m_ovf = 0; m_unf = 0;
    end else begin
      m_valid = 0;
      if (d) begin
        if (q_cnt > 0) begin
          m_out = q[q_head]; q_head = (q_head + 1) % DEPTH; q_cnt--; m_valid = 1;
        end else m_unf = 1;
      end
      if (a) begin
        if (q_cnt < DEPTH) begin
          q[(q_head + q_cnt) % DEPTH] = stamp; q_cnt++;
        end else m_ovf = 1;
      end
      if (m_tick == LAST) begin m_tick = 1; m_turn = m_turn + 1'b1; end
      else m_tick++;
    end
    if (f_mtick == LAST) begin f_mtick = 1; f_mturn = f_mturn + 1'b1; end
    else f_mtick++;
    @(negedge clk);
    acc = 0; dec = 0; init = 0;
    check_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 tick", 32'(tick), 1);
    chk("R1 turn", 32'(turn), 0);
    chk("R1 flags", 32'({empty, full, ovf, unf, valid}), 32'(5'b10000));
    chk("R1 popped", 32'({l1_turn, l1_tick}), 0);
    rst = 0;
    check_all();

    // R2 R3 free counting across two wraps
    for (int i = 0; i < 2 * LAST + 5; i++) cycle(0, 0, 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [18:0] e;
      e = VECS[v];
      for (int r = 0; r < int'(e[18:11]); r++) begin
        cycle(e[2], e[1], e[0]);
        for (int g = 0; g < int'(e[10:3]); g++) cycle(0, 0, 0);
      end
    end

    // R4 directed: init restarts counts, clears store and flags
    cycle(1, 0, 0);
    cycle(0, 1, 0);
    cycle(0, 1, 0);
    cycle(0, 0, 1);
    chk("R4 tick", 32'(tick), 1);
    chk("R4 turn", 32'(turn), 0);
    chk("R4 cleared", 32'({empty, ovf, unf}), 32'(3'b100));
    chk("R5 free not reset", 32'(f_tick == 8'd1 && f_turn == 16'd0), 0);

    // R7 directed: order of release
    for (int k = 0; k < 3; k++) begin
      cap[k] = {turn, tick};
      cycle(1, 0, 0);
      for (int g = 0; g < 10 + k; g++) cycle(0, 0, 0);
    end
    for (int k = 0; k < 3; k++) begin
      cycle(0, 1, 0);
      chk("R7 order", 32'({l1_turn, l1_tick}), 32'(cap[k]));
    end

    // R10 directed: push and pop while full
    cycle(0, 0, 1);
    for (int k = 0; k < DEPTH; k++) cycle(1, 0, 0);
    chk("R11 full at depth", 32'(full), 1);
    cycle(1, 1, 0);
    chk("R10 still full", 32'(full), 1);
    chk("R10 no overflow", 32'(ovf), 0);
    chk("R10 valid", 32'(valid), 1);
    cycle(1, 0, 0);
    chk("R8 overflow set", 32'(ovf), 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule